// File: doc/BRIEF.md
# Widening Signed-by-Unsigned Vector Multiplier

This execution unit takes one vector source register of signed elements and one scalar register. It multiplies every element by the scalar and produces products twice as wide as the elements. The scalar is read as an unsigned number. Because the products are twice as wide, the results fill two destination registers. Destination register 0 holds the lower half of the element indices and destination register 1 holds the upper half. Within each register the elements run in ascending order.

Each element position is classified before it is written:

- **Prestart:** the index is below the start index.
- **Tail:** the index is at or above the active length.
- **Masked off:** masking is enabled and the element's bit in the mask register is 0.
- **Written:** any other element receives its product.

Two policy bits decide what happens to tail and masked-off elements. With a policy bit clear, the old destination value is kept. With it set, the element is written as all ones. Prestart elements always keep the old value.

A request is accepted with a valid/ready handshake. The result comes back one cycle later on an output valid/ready handshake. The result is held until it is taken.

Top module: `vwide_mul_unit`

## Requirements
- R1: Each written element is the source element read as signed two's complement times the scalar read as unsigned, truncated to 2*SEW bits. For element i, the product sits at bits [i*2*SEW +: 2*SEW] of the 256-bit pair {dest1, dest0}.
- R2: Only the low SEW bits of the scalar take part in the multiply. Bits of the scalar above SEW have no effect on any result.
- R3: The old destination value never changes a written element. There is no accumulation.
- R4: An element is active only when its index is at least vstart and less than vl. Only active elements can receive a product.
- R5: When mask_en_i is 1, an active element is written only if its bit v0_i[i] is 1. When mask_en_i is 0, every active element is written and v0_i has no effect.
- R6: A tail element (index ≥ vl, index ≥ vstart) keeps its old value when tail_agn_i is 0. It becomes all ones when tail_agn_i is 1.
- R7: A masked-off active element keeps its old value when mask_agn_i is 0. It becomes all ones when mask_agn_i is 1.
- R8: An element with index below vstart keeps its old value under every policy setting.
- R9: The SEW encoding is 00 for 8, 01 for 16 and 10 for 32. The encoding 11 raises illegal_o with the result and returns the old destination registers unchanged. Legal encodings give illegal_o = 0.
- R10: A request is taken only on a cycle where in_valid and in_ready are both 1. The result appears with out_valid on the next cycle. While out_valid is 1 and out_ready is 0, the outputs stay unchanged and in_ready is 0.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can take a request |
| vs2_i | input | VLEN | Signed vector source register |
| scalar_i | input | XLEN | Unsigned scalar operand |
| v0_i | input | VLEN/8 | Per-element mask bits |
| mask_en_i | input | 1 | Enable masking by v0_i |
| vl_i | input | CNT_W | Active length |
| vstart_i | input | CNT_W | Start index |
| sew_i | input | 2 | Element width select |
| tail_agn_i | input | 1 | Tail policy: 1 writes ones |
| mask_agn_i | input | 1 | Mask policy: 1 writes ones |
| old0_i | input | VLEN | Old destination register 0 |
| old1_i | input | VLEN | Old destination register 1 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| dest0_o | output | VLEN | Destination register 0 result |
| dest1_o | output | VLEN | Destination register 1 result |
| illegal_o | output | 1 | Reserved width encoding was requested |

## Verification
The hardest case to reach is an element where several rules apply at once. Examples are an index that is both below vstart and at or beyond vl, or a masked-off element sitting next to tail elements, each under both policy settings. Directed requests set vstart above zero together with a short vl, a sparse v0 pattern and the agnostic policies. They also include a request with vstart greater than vl. A second hard case is a request arriving while the output is stalled. This is reached with a phase that drives out_ready randomly while requests are queued back to back.

// File: rtl/vwm_pkg.sv
`timescale 1ns/1ps
package vwm_pkg;
    typedef enum logic [1:0] {
        SEW_8   = 2'b00,
        SEW_16  = 2'b01,
        SEW_32  = 2'b10,
        SEW_RSV = 2'b11
    } sew_sel_e;

    typedef enum logic [1:0] {
        ELEM_PRE,
        ELEM_ON,
        ELEM_OFF,
        ELEM_TAIL
    } elem_kind_e;
endpackage

// File: rtl/vwm_lane.sv
`timescale 1ns/1ps
// One element: signed x unsigned product and policy select.
module vwm_lane
    import vwm_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic [EW-1:0]   src_i,
    input  logic [EW-1:0]   sc_i,
    input  logic [2*EW-1:0] old_i,
    input  elem_kind_e      kind_i,
    input  logic            tail_agn_i,
    input  logic            mask_agn_i,
    output logic [2*EW-1:0] res_o
);
    localparam int PW = 2 * EW;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] prod;

    assign a_ext = signed'({{EW{src_i[EW-1]}}, src_i});
    assign b_ext = signed'({{EW{1'b0}}, sc_i});
    assign prod  = a_ext * b_ext;

    always_comb begin
        case (kind_i)
            ELEM_ON:   res_o = prod;
            ELEM_OFF:  res_o = mask_agn_i ? {PW{1'b1}} : old_i;
            ELEM_TAIL: res_o = tail_agn_i ? {PW{1'b1}} : old_i;
            default:   res_o = old_i;
        endcase
    end
endmodule

// File: rtl/vwm_sew_path.sv
`timescale 1ns/1ps
// All elements of the register for one element width.
module vwm_sew_path
    import vwm_pkg::*;
#(
    parameter int VLEN  = 128,
    parameter int EW    = 8,
    parameter int CNT_W = 5
) (
    input  logic [VLEN-1:0]    vs2_i,
    input  logic [EW-1:0]      sc_i,
    input  logic [VLEN/EW-1:0] v0_i,
    input  logic               mask_en_i,
    input  logic [CNT_W-1:0]   vl_i,
    input  logic [CNT_W-1:0]   vstart_i,
    input  logic               tail_agn_i,
    input  logic               mask_agn_i,
    input  logic [2*VLEN-1:0]  old_i,
    output logic [2*VLEN-1:0]  res_o
);
    localparam int NELEM = VLEN / EW;
    localparam int PW    = 2 * EW;

    for (genvar i = 0; i < NELEM; i++) begin : g_elem
        logic [CNT_W-1:0] idx;
        elem_kind_e       kind;

        assign idx = CNT_W'(i);

        // Prestart outranks tail; tail outranks mask.
        always_comb begin
            if (idx < vstart_i)               kind = ELEM_PRE;
            else if (idx >= vl_i)             kind = ELEM_TAIL;
            else if (mask_en_i && !v0_i[i])   kind = ELEM_OFF;
            else                              kind = ELEM_ON;
        end

        vwm_lane #(.EW(EW)) u_lane (
            .src_i      (vs2_i[i*EW +: EW]),
            .sc_i       (sc_i),
            .old_i      (old_i[i*PW +: PW]),
            .kind_i     (kind),
            .tail_agn_i (tail_agn_i),
            .mask_agn_i (mask_agn_i),
            .res_o      (res_o[i*PW +: PW])
        );
    end
endmodule

// File: rtl/vwide_mul_unit.sv
`timescale 1ns/1ps
module vwide_mul_unit
    import vwm_pkg::*;
#(
    parameter  int VLEN   = 128,
    parameter  int XLEN   = 32,
    localparam int MASK_W = VLEN / 8,
    localparam int CNT_W  = $clog2(MASK_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VLEN-1:0]   vs2_i,
    input  logic [XLEN-1:0]   scalar_i,
    input  logic [MASK_W-1:0] v0_i,
    input  logic              mask_en_i,
    input  logic [CNT_W-1:0]  vl_i,
    input  logic [CNT_W-1:0]  vstart_i,
    input  logic [1:0]        sew_i,
    input  logic              tail_agn_i,
    input  logic              mask_agn_i,
    input  logic [VLEN-1:0]   old0_i,
    input  logic [VLEN-1:0]   old1_i,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [VLEN-1:0]   dest0_o,
    output logic [VLEN-1:0]   dest1_o,
    output logic              illegal_o
);
    localparam int NWIDTH = 3;

    typedef struct packed {
        logic              vld;
        logic              ill;
        logic [2*VLEN-1:0] res;
    } out_st_t;

    out_st_t           st_d, st_q;
    logic [2*VLEN-1:0] old_all;
    logic [2*VLEN-1:0] res_w [NWIDTH];
    logic [2*VLEN-1:0] res_sel;
    logic              fire;
    sew_sel_e          sew_e;

    assign old_all = {old1_i, old0_i};
    assign sew_e   = sew_sel_e'(sew_i);

    for (genvar w = 0; w < NWIDTH; w++) begin : g_width
        localparam int EW = 8 << w;
        vwm_sew_path #(.VLEN(VLEN), .EW(EW), .CNT_W(CNT_W)) u_path (
            .vs2_i      (vs2_i),
            .sc_i       (scalar_i[EW-1:0]),
            .v0_i       (v0_i[VLEN/EW-1:0]),
            .mask_en_i  (mask_en_i),
            .vl_i       (vl_i),
            .vstart_i   (vstart_i),
            .tail_agn_i (tail_agn_i),
            .mask_agn_i (mask_agn_i),
            .old_i      (old_all),
            .res_o      (res_w[w])
        );
    end

    assign in_ready = !st_q.vld || out_ready;
    assign fire     = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        case (sew_e)
            SEW_8:   res_sel = res_w[0];
            SEW_16:  res_sel = res_w[1];
            SEW_32:  res_sel = res_w[2];
            default: res_sel = old_all;
        endcase
        if (fire) begin
            st_d.vld = 1'b1;
            st_d.ill = (sew_e == SEW_RSV);
            st_d.res = res_sel;
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign illegal_o = st_q.ill;
    assign dest0_o   = st_q.res[VLEN-1:0];
    assign dest1_o   = st_q.res[2*VLEN-1:VLEN];
endmodule

// File: rtl/vwm_chk.sv
`timescale 1ns/1ps
module vwm_chk #(
    parameter int VLEN  = 128,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [CNT_W-1:0] vstart_i,
    input logic [1:0]       sew_i,
    input logic [VLEN-1:0]  old0_i,
    input logic [VLEN-1:0]  old1_i,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VLEN-1:0]  dest0_o,
    input logic [VLEN-1:0]  dest1_o,
    input logic             illegal_o
);
    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(dest0_o) && $stable(dest1_o) && $stable(illegal_o));

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R10
    accept_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R9
    bad_sew_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && sew_i == 2'b11 |=>
            illegal_o && dest0_o == $past(old0_i) && dest1_o == $past(old1_i));

    // R8
    prestart_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && sew_i == 2'b00 && vstart_i != '0 |=>
            dest0_o[15:0] == $past(old0_i[15:0]));
endmodule

bind vwide_mul_unit vwm_chk #(.VLEN(VLEN), .CNT_W(CNT_W)) i_vwm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .vstart_i  (vstart_i),
    .sew_i     (sew_i),
    .old0_i    (old0_i),
    .old1_i    (old1_i),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .dest0_o   (dest0_o),
    .dest1_o   (dest1_o),
    .illegal_o (illegal_o)
);

// File: tb/test_vwide_mul_unit.sv
`timescale 1ns/1ps
module test_vwide_mul_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] vs2_i = '0;
    logic [31:0]  scalar_i = '0;
    logic [15:0]  v0_i = '0;
    logic         mask_en_i = 1'b0;
    logic [4:0]   vl_i = '0;
    logic [4:0]   vstart_i = '0;
    logic [1:0]   sew_i = '0;
    logic         tail_agn_i = 1'b0;
    logic         mask_agn_i = 1'b0;
    logic [127:0] old0_i = '0;
    logic [127:0] old1_i = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] dest0_o;
    logic [127:0] dest1_o;
    logic         illegal_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    bit ready_rand = 0;

    // reference state
    bit           exp_vld = 0;
    bit           exp_ill = 0;
    logic [255:0] exp_res = '0;
    string        exp_tag = "R11";
    string        cur_tag = "R1";
    bit           took = 0;

    always #2 clk = ~clk;

    vwide_mul_unit i_vwide_mul_unit (.*);

    function automatic logic [255:0] model(input logic [127:0] src, input logic [31:0] sc,
        input logic [15:0] msk, input bit men, input int vl, input int vst, input int sew,
        input bit ta, input bit ma, input logic [255:0] old);
        logic [255:0] r;
        int ew;
        int n;
        r = old;
        if (sew == 3) return old;
        ew = 8 << sew;
        n = 128 / ew;
        for (int i = 0; i < n; i++) begin
            longint a = 0;
            longint b = 0;
            longint p;
            for (int k = 0; k < ew; k++) begin
                a[k] = src[i*ew+k];
                b[k] = sc[k];
            end
            if (src[i*ew+ew-1]) a = a - (64'sd1 <<< ew);
            p = a * b;
            if (i < vst) begin
            end else if (i >= vl) begin
                if (ta) for (int k = 0; k < 2*ew; k++) r[i*2*ew+k] = 1'b1;
            end else if (men && !msk[i]) begin
                if (ma) for (int k = 0; k < 2*ew; k++) r[i*2*ew+k] = 1'b1;
            end else begin
                for (int k = 0; k < 2*ew; k++) r[i*2*ew+k] = p[k];
            end
        end
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // per-clock comparison and reference update, away from the active edge
    always @(negedge clk) begin
        bit mrdy;
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
        if (!rst_n) begin
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R11 out_valid in reset: actual %b expected 0", out_valid);
            end
            took = 0;
        end else begin
            mrdy = !exp_vld || out_ready;
            checks++;
            if (out_valid !== exp_vld || in_ready !== mrdy) begin
                errors++;
                $display("FAIL R10 handshake: actual vld=%b rdy=%b expected vld=%b rdy=%b",
                         out_valid, in_ready, exp_vld, mrdy);
            end
            if (exp_vld) begin
                checks++;
                if ({dest1_o, dest0_o} !== exp_res || illegal_o !== exp_ill) begin
                    errors++;
                    $display("FAIL %s result: actual ill=%b %h expected ill=%b %h",
                             exp_tag, illegal_o, {dest1_o, dest0_o}, exp_ill, exp_res);
                end
            end
            took = in_valid && mrdy;
            if (took) begin
                exp_vld = 1;
                exp_ill = (sew_i == 2'b11);
                exp_res = model(vs2_i, scalar_i, v0_i, mask_en_i, int'(vl_i), int'(vstart_i),
                                int'(sew_i), tail_agn_i, mask_agn_i, {old1_i, old0_i});
                exp_tag = cur_tag;
            end else if (out_ready) begin
                exp_vld = 0;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1 out_ready = ready_rand ? 1'($urandom % 2) : 1'b1;
        end
    end

    task automatic send(input string tag, input logic [127:0] src, input logic [31:0] sc,
        input logic [15:0] msk, input bit men, input int vl, input int vst, input int sew,
        input bit ta, input bit ma, input logic [255:0] old);
        cur_tag    = tag;
        vs2_i      = src;
        scalar_i   = sc;
        v0_i       = msk;
        mask_en_i  = men;
        vl_i       = 5'(vl);
        vstart_i   = 5'(vst);
        sew_i      = 2'(sew);
        tail_agn_i = ta;
        mask_agn_i = ma;
        {old1_i, old0_i} = old;
        in_valid   = 1'b1;
        do @(posedge clk); while (!took);
        #1 in_valid = 1'b0;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [255:0] rnd256();
        return {rnd128(), rnd128()};
    endfunction

    initial begin
        logic [127:0] s;
        logic [255:0] o;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R11: ready after reset
        checks++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 after reset: actual rdy=%b vld=%b expected 1 0", in_ready, out_valid);
        end
        // R1: each width, full length, random and extreme operands
        for (int w = 0; w < 3; w++) begin
            send("R1", rnd128(), $urandom, '0, 0, 128 >> (3 + w), 0, w, 0, 0, rnd256());
            send("R1", {16{8'h80}}, 32'hFFFF_FFFF, '0, 0, 128 >> (3 + w), 0, w, 0, 0, rnd256());
            send("R1", {16{8'h7F}}, 32'hFFFF_FFFF, '0, 0, 128 >> (3 + w), 0, w, 0, 0, '0);
        end
        // R2: upper scalar bits ignored
        s = rnd128();
        send("R2", s, 32'hDEAD_BE05, '0, 0, 16, 0, 0, 0, 0, '0);
        send("R2", s, 32'h0000_0005, '0, 0, 16, 0, 0, 0, 0, '0);
        send("R2", s, 32'h1234_FFFF, '0, 0, 8, 0, 1, 0, 0, '0);
        // R3: old destination does not enter active elements
        send("R3", s, 32'h0000_9ABC, '0, 0, 8, 0, 1, 0, 0, {256{1'b1}});
        send("R3", s, 32'h0000_9ABC, '0, 0, 8, 0, 1, 0, 0, '0);
        // R4: active window
        send("R4", rnd128(), $urandom, '0, 0, 5, 2, 1, 0, 0, rnd256());
        send("R4", rnd128(), $urandom, '0, 0, 3, 3, 0, 1, 1, rnd256());
        // R5: masking enabled and disabled
        o = rnd256();
        send("R5", s, 32'h0000_00C3, 16'hA5C3, 1, 16, 0, 0, 0, 0, o);
        send("R5", s, 32'h0000_00C3, 16'h0000, 0, 16, 0, 0, 0, 0, o);
        // R6: tail policy
        send("R6", rnd128(), $urandom, '0, 0, 2, 0, 2, 1, 0, o);
        send("R6", rnd128(), $urandom, '0, 0, 2, 0, 2, 0, 1, o);
        // R7: mask policy
        send("R7", s, $urandom, 16'h0F0F, 1, 8, 0, 1, 0, 1, o);
        send("R7", s, $urandom, 16'h0F0F, 1, 8, 0, 1, 1, 0, o);
        // R8: prestart under agnostic policies, and vstart beyond vl
        send("R8", s, $urandom, 16'h0000, 1, 10, 4, 0, 1, 1, o);
        send("R8", s, $urandom, 16'hFFFF, 1, 2, 6, 0, 1, 1, o);
        // R9: reserved width
        send("R9", s, $urandom, '1, 0, 16, 0, 3, 1, 1, o);
        send("R9", s, $urandom, '1, 0, 16, 0, 2, 1, 1, o);
        // R10: random back-pressure, back-to-back requests
        ready_rand = 1;
        for (int k = 0; k < 40; k++) begin
            send("R10", rnd128(), $urandom, 16'($urandom), 1'($urandom), int'($urandom % 17),
                 int'($urandom % 6), int'($urandom % 4), 1'($urandom), 1'($urandom), rnd256());
        end
        ready_rand = 0;
        repeat (6) @(posedge clk);
        #1 finish_run();
    end
endmodule